// File: doc/BRIEF.md
# Conversion Sequencer for a Successive-Approximation ADC

This block is the digital control side of a successive-approximation converter. Software reaches it through one 8-bit control/status register. The register holds an enable, a start/busy bit, an auto-trigger enable, a completion flag, an interrupt enable and a 3-bit clock divider select. The block divides the system clock down to a converter clock and times each conversion in converter clock cycles. A conversion starts on a software request or on a rising edge of an external trigger line.

When a conversion ends, the block latches a 10-bit word from its data input into the result output and sets the completion flag in the same cycle. An interrupt request is raised when the flag, the interrupt enable and the global interrupt enable are all one. The first conversion after the converter is switched on runs longer, to cover the converter's initialization.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the result is zero and `irq` is low.
- R2: A write with bit 7 (enable) and bit 6 (start) both one begins a conversion. Bit 6 then reads one for as long as the conversion runs and returns to zero by itself at the end. A write with bit 6 zero starts nothing.
- R3: The first conversion after enable goes from 0 to 1 lasts 25 converter clocks. When enable and start are written together, bit 6 is high for exactly 25 × ratio system clocks.
- R4: Each later conversion lasts 13 converter clocks. Because the divider phase is free, bit 6 stays high between 12 × ratio + 1 and 13 × ratio system clocks.
- R5: Bits 2:0 select the divide ratio. Codes 0 to 7 give 2, 2, 4, 8, 16, 32, 64 and 128.
- R6: At the end of a conversion, `result` takes the value of `conv_data` and the flag (bit 4) is set in the same cycle. `result` changes at no other time.
- R7: The flag is cleared by writing one to bit 4 or by a one-cycle `irq_ack` pulse. Writing zero to bit 4 leaves it unchanged. A completion in the same cycle wins over a clear.
- R8: `irq` is high exactly when the flag, bit 3 (interrupt enable) and `gie` are all one.
- R9: With bit 5 (auto-trigger) set, a rising edge of `trig_in` starts a conversion. A level held high starts no further conversion. With bit 5 clear, `trig_in` has no effect.
- R10: Writing bit 7 to zero stops a running conversion at once. Bit 6 reads zero, no result is latched and no flag is set. The divider restarts from zero on the next enable.
- R11: A start write or trigger edge that arrives while a conversion runs is ignored. The running conversion keeps its original length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value, with bit 6 as busy |
| trig_in | input | 1 | External conversion trigger |
| irq_ack | input | 1 | Interrupt-taken pulse; clears the flag |
| gie | input | 1 | Global interrupt enable |
| conv_data | input | 10 | Converter output word, sampled at the end of a conversion |
| result | output | 10 | Latched conversion result |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
Enable and start are written together once for every divider code. The busy time must then equal exactly 25 times the ratio, which separates the long first conversion, the ratio decode and the divider reset on enable. Later starts follow random idle gaps at random ratios, and their busy time is checked against the 13-clock window, so a wrong normal length or a wrong tick period falls outside the bounds. Further directed cases cover the following:
- a start write during a conversion, which must leave the total length unchanged;
- a trigger that rises and is then held high, and the same edge with auto-trigger off;
- an abort part-way through a conversion;
- the four flag-clear paths, together with the interrupt enable and `gie` combinations.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W    = 10,
  parameter int PSC_W    = 3,
  parameter int NORM_LEN = 13,
  parameter int INIT_LEN = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             trig_in,
  input  logic             irq_ack,
  input  logic             gie,
  input  logic [RES_W-1:0] conv_data,
  output logic [RES_W-1:0] result,
  output logic             irq
);
  localparam int DIV_W = (1 << PSC_W) - 1;
  localparam int CNT_W = $clog2(INIT_LEN + 1);

  logic             en, busy, ate, flag, ie, fresh, long_q, trig_q;
  logic [PSC_W-1:0] ps;
  logic [DIV_W-1:0] pcnt, plim;
  logic [CNT_W-1:0] ccnt, last_idx;
  logic             en_nx, tick, sw_go, hw_go, go, fresh_now, done;

  assign en_nx     = reg_we ? reg_wdata[7] : en;
  assign plim      = (ps == '0) ? DIV_W'(1) : DIV_W'((1 << ps) - 1);
  assign tick      = en & (pcnt >= plim);
  assign sw_go     = reg_we & reg_wdata[7] & reg_wdata[6];
  assign hw_go     = ate & en & trig_in & ~trig_q;
  assign go        = (sw_go | hw_go) & ~busy & en_nx;
  assign fresh_now = fresh | (reg_we & reg_wdata[7] & ~en);
  assign last_idx  = long_q ? CNT_W'(INIT_LEN - 1) : CNT_W'(NORM_LEN - 1);
  assign done      = busy & tick & (ccnt == last_idx) & en_nx;

  assign reg_rdata = {en, busy, ate, flag, ie, ps};
  assign irq       = flag & ie & gie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; ate <= 1'b0; ie <= 1'b0; ps <= '0;
    end else if (reg_we) begin
      en  <= reg_wdata[7];
      ate <= reg_wdata[5];
      ie  <= reg_wdata[3];
      ps  <= reg_wdata[PSC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) pcnt <= '0;
    else                       pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ccnt <= '0; long_q <= 1'b0; fresh <= 1'b0;
    end else begin
      if (go)                          fresh <= 1'b0;
      else if (reg_we && reg_wdata[7] && !en) fresh <= 1'b1;
      if (!en_nx) begin
        busy <= 1'b0;
        ccnt <= '0;
      end else if (go) begin
        busy   <= 1'b1;
        ccnt   <= '0;
        long_q <= fresh_now;
      end else if (busy && tick) begin
        if (ccnt == last_idx) busy <= 1'b0;
        else                  ccnt <= ccnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      result <= '0;
    end else if (done) begin
      flag   <= 1'b1;
      result <= conv_data;
    end else if (irq_ack || (reg_we && reg_wdata[4])) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [7:0]       reg_rdata,
  input logic             trig_in,
  input logic             irq_ack,
  input logic             gie,
  input logic [RES_W-1:0] result,
  input logic             irq
);
  p_busy_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] |-> reg_rdata[7]);

  p_flag_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reg_rdata[6]) && reg_rdata[7]) |-> reg_rdata[4]);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !($fell(reg_rdata[6]) && reg_rdata[7]) |-> $stable(result));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && reg_rdata[3] && reg_rdata[4]));

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !reg_rdata[6]) |=> !reg_rdata[4]);

  p_edge_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && reg_rdata[5] && !reg_rdata[6] && $rose(trig_in) && !reg_we)
    |=> reg_rdata[6]);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .trig_in(trig_in), .irq_ack(irq_ack), .gie(gie), .result(result), .irq(irq)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, trig_in = 1'b0;
  logic       irq_ack = 1'b0, gie = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [9:0] conv_data = '0, result;
  logic       irq;
  int checks = 0, fails = 0;

  adc_seq_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ratio(input int code);
    return (code == 0) ? 2 : (1 << code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic run_busy(output int n);
    n = 0;
    while (reg_rdata[6]) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, lo, hi;
    logic [9:0] keep;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata == 8'h00, "R1 reg", reg_rdata, 0);
    check(result == 0 && irq == 0, "R1 out", result, 0);

    for (int c = 0; c < 8; c++) begin
      wr(8'h00);
      conv_data = 10'($urandom);
      wr(8'hC0 | 8'(c));
      check(reg_rdata[6], "R2 busy", reg_rdata[6], 1);
      run_busy(n);
      check(n == 25 * ratio(c), "R3/R5 first length", n, 25 * ratio(c));
      check(result == conv_data && reg_rdata[4], "R6 result", result, conv_data);
      if (c < 4) begin
        conv_data = 10'($urandom);
        wr(8'hC0 | 8'(c));
        run_busy(n);
        check(n >= 12 * ratio(c) + 1 && n <= 13 * ratio(c), "R4 normal length", n, 13 * ratio(c));
        check(result == conv_data, "R6 result", result, conv_data);
      end
    end

    for (int i = 0; i < 6; i++) begin
      int c = int'($urandom_range(0, 3));
      wr(8'h80 | 8'(c));
      repeat ($urandom_range(0, 20)) @(negedge clk);
      conv_data = 10'($urandom);
      wr(8'hC0 | 8'(c));
      run_busy(n);
      check(n >= 12 * ratio(c) + 1 && n <= 13 * ratio(c), "R4 random length", n, 13 * ratio(c));
      check(result == conv_data, "R6 random result", result, conv_data);
    end

    wr(8'h80);
    repeat (5) @(negedge clk);
    check(!reg_rdata[6], "R2 start zero", reg_rdata[6], 0);
    check(reg_rdata[4], "R7 write zero keeps flag", reg_rdata[4], 1);
    wr(8'h90);
    check(!reg_rdata[4], "R7 write one clears", reg_rdata[4], 0);

    conv_data = 10'($urandom);
    wr(8'hC0); run_busy(n);
    wr(8'h88);
    gie = 1'b0; @(negedge clk);
    check(irq == 1'b0, "R8 gie off", irq, 0);
    gie = 1'b1; @(negedge clk);
    check(irq == 1'b1, "R8 all on", irq, 1);
    wr(8'h80); @(negedge clk);
    check(irq == 1'b0, "R8 ie off", irq, 0);
    wr(8'h88);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check(!reg_rdata[4] && !irq, "R7 ack clears", reg_rdata[4], 0);

    wr(8'hC0);
    repeat (10) @(negedge clk);
    wr(8'hC0);
    run_busy(lo);
    n = lo + 11;
    check(n == 26 || (n >= 25 && n <= 26), "R11 start while busy", n, 26);

    wr(8'hA0);
    conv_data = 10'($urandom);
    trig_in = 1'b1;
    @(negedge clk);
    check(reg_rdata[6], "R9 edge starts", reg_rdata[6], 1);
    run_busy(n);
    check(result == conv_data, "R9 trigger result", result, conv_data);
    repeat (40) @(negedge clk);
    check(!reg_rdata[6], "R9 level no retrigger", reg_rdata[6], 0);
    trig_in = 1'b0;
    wr(8'h80);
    trig_in = 1'b1; repeat (3) @(negedge clk);
    check(!reg_rdata[6], "R9 auto-trigger off", reg_rdata[6], 0);
    trig_in = 1'b0;

    wr(8'h90);
    keep = result;
    conv_data = ~keep;
    wr(8'hC3);
    repeat (30) @(negedge clk);
    wr(8'h03);
    check(!reg_rdata[6], "R10 abort busy", reg_rdata[6], 0);
    repeat (300) @(negedge clk);
    check(result == keep && !reg_rdata[4], "R10 no result", result, keep);
    conv_data = 10'($urandom);
    wr(8'hC3);
    run_busy(hi);
    check(hi == 25 * 8, "R10 divider restart", hi, 200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule